// File: doc/BRIEF.md
# Vector Element Address Generator

This block turns one strided vector memory operation into a stream of per-element effective addresses. A single-cycle start pulse captures a 64-bit base value, a flag that forces the base to zero, a 16-bit signed displacement, an access size in bytes, a post-shift amount, a vector length and a 2-bit walk mode. The block then presents one address per cycle on a valid/ready output, stepping the element index from 0 to length-1. Each address carries its element index so that downstream logic can pick the matching destination register.

Three walks are offered. Unit stride places elements back to back at the access size after the displacement. Element stride uses the displacement itself as the distance between elements. Bit-reversed mode scales the displacement by the access size and by the bit-reversed index, then shifts the product left. This produces the radix-2 butterfly order that in-place FFT passes need. When the walk ends, a one-cycle done pulse follows. A bit-reversed request whose length is not a power of two gives a one-cycle error pulse instead, and no addresses are issued.

Top module: `vec_addr_gen`

## Requirements
- R1: After reset, `out_valid`, `done` and `err` are all low.
- R2: Mode 2'b01 with a non-zero displacement is element stride: element i has address B + sext(disp) * i, where B is the base term.
- R3: Mode 2'b01 with a displacement of zero walks as unit stride.
- R4: Mode 2'b00 is unit stride: element i has address B + sext(disp) + size * i.
- R5: Mode 2'b10 is bit-reversed: element i has address B + ((sext(disp) * size * rev(i)) << shamt). Here rev(i) reverses the low log2(vlen) bits of i, so for vlen=4 the offsets come out as 0,2,1,3.
- R6: When `base_zero` is high, the base term B is 0 whatever `base` holds. Otherwise B equals `base`.
- R7: Exactly `vlen` addresses are issued, with `out_idx` equal to 0,1,…,vlen-1. `out_valid` first rises in the cycle after start. `done` is high for exactly one cycle, the cycle after the last handshake. A request with vlen=0 outside bit-reversed mode issues nothing and pulses `done` in the cycle after start.
- R8: In mode 2'b10, a vlen that is not a power of two (0 included) pulses `err` for one cycle in the cycle after start. No address is issued and `done` stays low.
- R9: While `out_valid` is high and `out_ready` is low, `out_addr`, `out_idx` and `out_valid` hold. The index advances only on a valid-and-ready handshake.
- R10: Mode 2'b11 walks as unit stride.
- R11: The displacement is sign-extended to 64 bits, and all address arithmetic wraps modulo 2^64.
- R12: A start pulse that arrives while a walk is in progress is ignored. The running walk continues with its original operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture operands and begin a walk (ignored while busy) |
| base | input | 64 | Base register value |
| base_zero | input | 1 | Treat the base term as zero |
| disp | input | 16 | Signed displacement |
| size | input | 4 | Access size in bytes |
| shamt | input | 6 | Left shift applied in bit-reversed mode |
| vlen | input | 8 | Number of elements |
| mode | input | 2 | 00 unit, 01 element stride, 10 bit-reversed, 11 unit |
| out_valid | output | 1 | An address is presented |
| out_ready | input | 1 | Consumer accepts the address |
| out_addr | output | 64 | Effective address of the current element |
| out_idx | output | 8 | Index of the current element |
| done | output | 1 | One-cycle pulse after the last handshake |
| err | output | 1 | One-cycle pulse for a rejected bit-reversed request |

## Verification
The assertions check the handshake contract on every cycle. They cover holding under backpressure, the index stepping by one per handshake, `done` and `err` never coinciding with `out_valid`, and a busy-time start leaving the presented address alone. The address values for each walk cannot be seen by any single-cycle property. These are shown only by the bench's scenarios, which compare every issued address and index against a scoreboard. Those scenarios cover the bit-reversed order with a shift and a negative displacement, the zero-displacement and reserved-mode fallbacks, forced-zero bases, wraparound past 2^64 and the rejected lengths.

// File: rtl/vag_pkg.sv
package vag_pkg;

    localparam int ADDR_W  = 64;
    localparam int DISP_W  = 16;
    localparam int VL_W    = 8;
    localparam int SHIFT_W = 6;
    localparam int SIZE_W  = 4;
    localparam int LOG_W   = $clog2(VL_W + 1);

    typedef enum logic [1:0] {
        SEL_UNIT = 2'b00,
        SEL_ELEM = 2'b01,
        SEL_BREV = 2'b10,
        SEL_RSVD = 2'b11
    } mode_sel_e;

    typedef enum logic [1:0] {
        WALK_UNIT = 2'd0,
        WALK_ELEM = 2'd1,
        WALK_BREV = 2'd2
    } walk_e;

    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic               base_zero;
        logic [DISP_W-1:0]  disp;
        logic [SIZE_W-1:0]  size;
        logic [SHIFT_W-1:0] shamt;
        logic [VL_W-1:0]    vlen;
        mode_sel_e          mode;
    } op_req_t;

    typedef struct packed {
        walk_e              walk;
        logic [ADDR_W-1:0]  base_eff;
        logic [ADDR_W-1:0]  disp_ext;
        logic [ADDR_W-1:0]  first;
        logic [ADDR_W-1:0]  step;
        logic [LOG_W-1:0]   log2vl;
        logic [VL_W-1:0]    vlen;
        logic [SHIFT_W-1:0] shamt;
        logic [SIZE_W-1:0]  size;
        logic               bad;
    } walk_plan_t;

    function automatic logic [ADDR_W-1:0] sext_disp(input logic [DISP_W-1:0] d);
        return {{(ADDR_W-DISP_W){d[DISP_W-1]}}, d};
    endfunction

    function automatic logic is_pow2(input logic [VL_W-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction

    function automatic logic [LOG_W-1:0] top_bit(input logic [VL_W-1:0] v);
        logic [LOG_W-1:0] r;
        r = '0;
        for (int j = 0; j < VL_W; j++) begin
            if (v[j]) r = LOG_W'(j);
        end
        return r;
    endfunction

    function automatic logic [VL_W-1:0] bit_rev(input logic [VL_W-1:0] idx,
                                                input logic [LOG_W-1:0] k);
        logic [VL_W-1:0] r;
        r = '0;
        for (int j = 0; j < VL_W; j++) begin
            if (j < int'(k)) r[int'(k) - 1 - j] = idx[j];
        end
        return r;
    endfunction

endpackage

// File: rtl/vag_decode.sv
module vag_decode
    import vag_pkg::*;
(
    input  op_req_t    req,
    output walk_plan_t plan
);
    logic [ADDR_W-1:0] base_eff;
    logic [ADDR_W-1:0] dext;
    walk_e             walk;

    always_comb begin
        base_eff = req.base_zero ? '0 : req.base;
        dext     = sext_disp(req.disp);
        case (req.mode)
            SEL_ELEM: walk = (req.disp != '0) ? WALK_ELEM : WALK_UNIT;
            SEL_BREV: walk = WALK_BREV;
            default:  walk = WALK_UNIT;
        endcase
    end

    always_comb begin
        plan          = '0;
        plan.walk     = walk;
        plan.base_eff = base_eff;
        plan.disp_ext = dext;
        plan.vlen     = req.vlen;
        plan.shamt    = req.shamt;
        plan.size     = req.size;
        plan.log2vl   = top_bit(req.vlen);
        plan.bad      = (walk == WALK_BREV) && !is_pow2(req.vlen);
        case (walk)
            WALK_ELEM: begin
                plan.first = base_eff;
                plan.step  = dext;
            end
            WALK_BREV: begin
                plan.first = base_eff;
                plan.step  = '0;
            end
            default: begin
                plan.first = base_eff + dext;
                plan.step  = ADDR_W'(req.size);
            end
        endcase
    end
endmodule

// File: rtl/vag_seq.sv
module vag_seq
    import vag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  walk_plan_t        plan_in,
    input  logic              out_ready,
    output logic              busy,
    output logic [VL_W-1:0]   idx,
    output logic [ADDR_W-1:0] acc,
    output walk_plan_t        plan_q,
    output logic              done,
    output logic              err
);
    logic fire;
    logic last;

    assign fire = busy && out_ready;
    assign last = (idx == plan_q.vlen - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            idx    <= '0;
            acc    <= '0;
            plan_q <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (!busy && start) begin
                plan_q <= plan_in;
                idx    <= '0;
                acc    <= plan_in.first;
                if (plan_in.bad)              err  <= 1'b1;
                else if (plan_in.vlen == '0)  done <= 1'b1;
                else                          busy <= 1'b1;
            end else if (fire) begin
                acc <= acc + plan_q.step;
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // R7
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        fire && !last |=> busy && (idx == VL_W'($past(idx) + 1'b1)));

    // R9
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !out_ready |=> busy && $stable(idx));

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy && !done);
endmodule

// File: rtl/vag_addr.sv
module vag_addr
    import vag_pkg::*;
(
    input  walk_plan_t        plan_q,
    input  logic [VL_W-1:0]   idx,
    input  logic [ADDR_W-1:0] acc,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] scaled;
    logic [ADDR_W-1:0] rev_idx;
    logic [ADDR_W-1:0] product;
    logic [ADDR_W-1:0] shifted;

    always_comb begin
        scaled  = plan_q.disp_ext * ADDR_W'(plan_q.size);
        rev_idx = ADDR_W'(bit_rev(idx, plan_q.log2vl));
        product = scaled * rev_idx;
        shifted = product << plan_q.shamt;
        addr    = (plan_q.walk == WALK_BREV) ? (plan_q.base_eff + shifted) : acc;
    end
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
    import vag_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [63:0]  base,
    input  logic         base_zero,
    input  logic [15:0]  disp,
    input  logic [3:0]   size,
    input  logic [5:0]   shamt,
    input  logic [7:0]   vlen,
    input  logic [1:0]   mode,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [63:0]  out_addr,
    output logic [7:0]   out_idx,
    output logic         done,
    output logic         err
);
    op_req_t           req;
    walk_plan_t        plan_new;
    walk_plan_t        plan_q;
    logic              busy;
    logic [VL_W-1:0]   idx;
    logic [ADDR_W-1:0] acc;
    logic [ADDR_W-1:0] addr;

    always_comb begin
        req.base      = base;
        req.base_zero = base_zero;
        req.disp      = disp;
        req.size      = size;
        req.shamt     = shamt;
        req.vlen      = vlen;
        req.mode      = mode_sel_e'(mode);
    end

    vag_decode u_decode (
        .req  (req),
        .plan (plan_new)
    );

    vag_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .plan_in   (plan_new),
        .out_ready (out_ready),
        .busy      (busy),
        .idx       (idx),
        .acc       (acc),
        .plan_q    (plan_q),
        .done      (done),
        .err       (err)
    );

    vag_addr u_addr (
        .plan_q (plan_q),
        .idx    (idx),
        .acc    (acc),
        .addr   (addr)
    );

    assign out_valid = busy;
    assign out_addr  = addr;
    assign out_idx   = idx;

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_addr));

    // R7
    done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && out_valid));

    // R12
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && start |=> $stable(out_addr) && $stable(out_idx));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !out_valid && !done && !err);
endmodule

// File: tb/test_vec_addr_gen.sv
module test_vec_addr_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [63:0] base;
    logic        base_zero;
    logic [15:0] disp;
    logic [3:0]  size;
    logic [5:0]  shamt;
    logic [7:0]  vlen;
    logic [1:0]  mode;
    logic        out_valid;
    logic        out_ready;
    logic [63:0] out_addr;
    logic [7:0]  out_idx;
    logic        done;
    logic        err;

    always #10 clk = ~clk;

    vec_addr_gen i_vec_addr_gen (
        .clk(clk), .rst(rst), .start(start), .base(base), .base_zero(base_zero),
        .disp(disp), .size(size), .shamt(shamt), .vlen(vlen), .mode(mode),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_idx(out_idx), .done(done), .err(err)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    logic [63:0] q_addr[$];
    int          q_idx[$];
    string       cur_tag = "R1";
    int          rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic        prev_stall = 1'b0;
    logic [63:0] prev_addr = '0;
    logic [7:0]  prev_idx = '0;
    logic        mon_on = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rev_bits(input int i, input int k);
        logic [7:0] r;
        r = '0;
        for (int j = 0; j < k; j++) r[k-1-j] = i[j];
        return r;
    endfunction

    // scoreboard monitor: sets ready, then checks what the next edge will accept
    always @(negedge clk) begin
        if (mon_on) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (rdy_mode)
                0: out_ready = 1'b1;
                1: out_ready = ~out_ready;
                default: out_ready = lfsr[0] & lfsr[3];
            endcase
            if (out_valid && prev_stall) begin
                check(out_addr == prev_addr && out_idx == prev_idx,
                      "R9 hold under stall", out_addr, prev_addr);
            end
            if (out_valid && out_ready) begin
                if (q_addr.size() == 0) begin
                    check(1'b0, {cur_tag, " unexpected address"}, out_addr, 64'h0);
                end else begin
                    logic [63:0] ea;
                    int ei;
                    ea = q_addr.pop_front();
                    ei = q_idx.pop_front();
                    check(out_addr == ea, {cur_tag, " address"}, out_addr, ea);
                    check(int'(out_idx) == ei, {cur_tag, " R7 index"},
                          64'(out_idx), 64'(ei));
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_addr  = out_addr;
            prev_idx   = out_idx;
        end
    end

    task automatic run_op(input logic [1:0] m, input logic [63:0] b, input logic bz,
                          input logic [15:0] d, input logic [3:0] sz, input logic [5:0] sh,
                          input logic [7:0] vl, input int rm, input bit extra,
                          input string tag);
        logic [63:0] bb;
        logic [63:0] de;
        int          k;
        bit          bad;
        bit          pow2;
        int          w;
        cur_tag  = tag;
        rdy_mode = rm;
        bb = bz ? 64'h0 : b;
        de = {{48{d[15]}}, d};
        pow2 = (vl != 0) && ((vl & (vl - 8'd1)) == 0);
        k = 0;
        for (int j = 0; j < 8; j++) if (vl[j]) k = j;
        bad = (m == 2'b10) && !pow2;
        if (!bad) begin
            for (int i = 0; i < int'(vl); i++) begin
                logic [63:0] a;
                if (m == 2'b01 && d != 0)  a = bb + de * 64'(i);
                else if (m == 2'b10)       a = bb + ((de * 64'(sz) * 64'(rev_bits(i, k))) << sh);
                else                       a = bb + de + 64'(sz) * 64'(i);
                q_addr.push_back(a);
                q_idx.push_back(i);
            end
        end
        @(negedge clk);
        mode = m; base = b; base_zero = bz; disp = d; size = sz; shamt = sh; vlen = vl;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (bad) begin
            check(err == 1'b1 && out_valid == 1'b0, "R8 err pulse", 64'(err), 64'h1);
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                check(!out_valid && !done && !err, "R8 quiet after err",
                      64'({out_valid, done, err}), 64'h0);
            end
        end else if (vl == 0) begin
            check(done == 1'b1 && out_valid == 1'b0, "R7 empty walk done", 64'(done), 64'h1);
            @(negedge clk);
            check(done == 1'b0, "R7 done single cycle", 64'(done), 64'h0);
        end else begin
            check(out_valid == 1'b1, {tag, " R7 valid after start"}, 64'(out_valid), 64'h1);
            if (extra) begin
                @(negedge clk);
                mode = 2'b01; base = 64'h5555_0000; disp = 16'h0100; vlen = 8'd2;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            w = 0;
            while (!done && w < 2000) begin
                @(negedge clk);
                w++;
            end
            check(done == 1'b1 && q_addr.size() == 0, {tag, " R7 done after all"},
                  64'(q_addr.size()), 64'h0);
            @(negedge clk);
            check(done == 1'b0 && out_valid == 1'b0, {tag, " R7 done single cycle"},
                  64'({done, out_valid}), 64'h0);
        end
        q_addr.delete();
        q_idx.delete();
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; base = '0; base_zero = 1'b0; disp = '0; size = '0;
        shamt = '0; vlen = '0; mode = '0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && !done && !err, "R1 reset state",
              64'({out_valid, done, err}), 64'h0);
        mon_on = 1'b1;

        run_op(2'b01, 64'h10, 1'b0, 16'd24, 4'd4, 6'd0, 8'd2, 0, 1'b0, "R2 elem");
        run_op(2'b01, 64'h1000, 1'b0, 16'hFFF0, 4'd8, 6'd0, 8'd5, 2, 1'b0, "R2 R11 elem neg");
        run_op(2'b00, 64'h10, 1'b0, 16'd8, 4'd4, 6'd0, 8'd2, 0, 1'b0, "R4 unit");
        run_op(2'b00, 64'h200, 1'b0, 16'd0, 4'd2, 6'd0, 8'd7, 1, 1'b0, "R4 unit half");
        run_op(2'b01, 64'h40, 1'b0, 16'd0, 4'd4, 6'd0, 8'd3, 2, 1'b0, "R3 zero disp");
        run_op(2'b11, 64'h80, 1'b0, 16'd4, 4'd8, 6'd3, 8'd3, 0, 1'b0, "R10 reserved");
        run_op(2'b10, 64'h10, 1'b0, 16'd1, 4'd4, 6'd0, 8'd4, 0, 1'b0, "R5 brev4");
        run_op(2'b10, 64'h1000, 1'b0, 16'hFFFF, 4'd8, 6'd2, 8'd8, 2, 1'b0, "R5 R11 brev8 shift");
        run_op(2'b10, 64'h300, 1'b0, 16'd3, 4'd1, 6'd1, 8'd1, 1, 1'b0, "R5 brev1");
        run_op(2'b00, 64'hDEAD_BEEF, 1'b1, 16'd16, 4'd4, 6'd0, 8'd3, 0, 1'b0, "R6 base zero");
        run_op(2'b10, 64'hDEAD_0000, 1'b1, 16'd2, 4'd4, 6'd0, 8'd2, 2, 1'b0, "R6 brev base zero");
        run_op(2'b00, 64'hFFFF_FFFF_FFFF_FFF8, 1'b0, 16'd4, 4'd8, 6'd0, 8'd4, 1, 1'b0,
               "R11 wrap");
        run_op(2'b10, 64'h10, 1'b0, 16'd1, 4'd4, 6'd0, 8'd6, 0, 1'b0, "R8 vl6");
        run_op(2'b10, 64'h10, 1'b0, 16'd1, 4'd4, 6'd0, 8'd0, 0, 1'b0, "R8 vl0");
        run_op(2'b00, 64'h10, 1'b0, 16'd1, 4'd4, 6'd0, 8'd0, 0, 1'b0, "R7 empty");
        run_op(2'b00, 64'h400, 1'b0, 16'd8, 4'd4, 6'd0, 8'd8, 1, 1'b1, "R12 busy start");

        mon_on = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule